// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is an on-chip synchronous memory built for a shared data bus that switches between reads and writes with no idle cycles. On every rising clock edge it captures a command: an address, three chip selects, a write enable, one active-low strobe per 9-bit byte lane, and a load/advance control. Write data does not arrive with the command. It arrives on a later slot whose delay equals the read latency. A write can therefore follow a read, or a read follow a write, on consecutive edges with no gap on the data bus.

A parameter picks one of two modes. In pipelined mode, read data is held in an output register and write data is taken two edges after its command. In flow-through mode, both delays are one edge shorter. While a write is still waiting for its data, a read of the same address gets the new bytes from the data input instead of the stale array word. An active-high clock-enable bar freezes the whole block for a cycle. An active-low output enable turns the bus drivers off at once, without waiting for a clock edge. A 2-bit burst counter lets a command continue over four addresses, in either linear or interleaved order.

The data bus is split into `dq_in`, `dq_out` and a drive strobe `dq_oe`, so the pad ring can build the bidirectional pin from them. There is no valid/ready handshake. The bus is paced purely by command latency, and the only form of back-pressure is the clock-enable stall.

Top module: `lw_sram_core`

## Requirements
- R1: After synchronous reset `rst`, `dq_oe` is low and no read, write or burst is pending, so a continue command issued right after reset selects nothing.
- R2: A new access starts only when `load_n` is low on an enabled edge and `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other select combination with `load_n` low is a deselect: the bus is not driven for that command.
- R3: A read (`we_n`=1) issued at edge k presents the stored word on `dq_out` with `dq_oe` high for sampling at edge k+2 in pipelined mode, or at edge k+1 in flow-through mode.
- R4: A write (`we_n`=0) issued at edge k takes its data from `dq_in` at edge k+2 in pipelined mode, or at edge k+1 in flow-through mode, counting only edges with the clock enable active.
- R5: Bit i of `lane_wr_n` controls `dq_in[9i+8:9i]`. A low bit writes that lane and a high bit leaves it unchanged, and any subset of lanes may be written.
- R6: Reads and writes may alternate on consecutive edges with no idle cycle. A read of an address whose write data is still in flight returns the new lanes merged over the old ones.
- R7: With `load_n` high, the previous command type continues. The low two address bits advance from the loaded start value, as start+n mod 4 when LINEAR_BURST=1 or as start XOR n when LINEAR_BURST=0. They return to the start value on the fifth access, and the upper bits stay fixed.
- R8: A continue that follows a deselect (or reset) is also a deselect.
- R9: An edge with `clk_en_n` high changes no state. `dq_out` and `dq_oe` keep their values, and no array write happens.
- R10: `dq_oe` is low during the data cycle of every write, including aborted writes.
- R11: `oe_n` high forces `dq_oe` low at once, without waiting for a clock edge.
- R12: A write with every `lane_wr_n` bit high is an abort that changes no stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock-enable bar; high freezes the block for that edge |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Low for write, high for read |
| load_n | input | 1 | Low loads a new command and address; high continues the burst |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | LANES*LANE_W | Read data to the bus (zero while not driven) |
| dq_oe | output | 1 | High while the block drives the bus |

## Verification
Two instances are driven from the same inputs: a pipelined one with linear bursts and a flow-through one with interleaved bursts. Any difference in latency or address order between them shows up against a cycle-accurate behavioural model.

The directed patterns are:
- Back-to-back write/read pairs on one address. These tell in-flight forwarding apart from a plain array read.
- Partial-lane writes and all-strobes-high aborts. These separate per-lane masking from whole-word writes.
- Bursts that start at unaligned low bits. These separate the linear order from the interleaved order and show the wrap.
- Stalls dropped into reads and into writes, plus partial chip-select patterns and mid-cycle output-enable toggles.

A long random run over eight addresses then mixes all of these, so that address hits across the write pipeline are frequent.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } lw_op_e;

  // low two address bits of the n-th access of a burst
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       linear);
    return linear ? (start + step) : (start ^ step);
  endfunction

endpackage

// File: rtl/lw_cmd_decode.sv
module lw_cmd_decode
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int LANES        = 2,
  parameter bit LINEAR_BURST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              we_n,
  input  logic              load_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  output lw_op_e            op,
  output logic [ADDR_W-1:0] op_addr,
  output logic [LANES-1:0]  op_mask
);

  lw_op_e            burst_op_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q;
  logic [1:0]        step_nx;
  logic              selected;

  always_comb begin
    selected = !sel_a_n && sel_b && !sel_c_n;
    step_nx  = step_q + 2'd1;
    if (!load_n) begin
      op      = selected ? (we_n ? OP_RD : OP_WR) : OP_NONE;
      op_addr = addr;
    end else begin
      op      = burst_op_q;
      op_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], step_nx, LINEAR_BURST)};
    end
    op_mask = (op == OP_WR) ? ~lane_wr_n : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_op_q <= OP_NONE;
      base_q     <= '0;
      step_q     <= '0;
    end else if (en) begin
      if (!load_n) begin
        burst_op_q <= op;
        base_q     <= addr;
        step_q     <= '0;
      end else if (burst_op_q != OP_NONE) begin
        step_q <= step_nx;
      end
    end
  end

endmodule

// File: rtl/lw_cmd_pipe.sv
module lw_cmd_pipe
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 2,
  parameter bit PIPELINED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  lw_op_e            in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_mask,
  output lw_op_e            s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output lw_op_e            cm_op,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [LANES-1:0]  cm_mask
);

  logic [LANES-1:0] s1_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op   <= OP_NONE;
      s1_addr <= '0;
      s1_mask <= '0;
    end else if (en) begin
      s1_op   <= in_op;
      s1_addr <= in_addr;
      s1_mask <= in_mask;
    end
  end

  generate
    if (PIPELINED) begin : g_late2
      lw_op_e            s2_op;
      logic [ADDR_W-1:0] s2_addr;
      logic [LANES-1:0]  s2_mask;
      always_ff @(posedge clk) begin
        if (rst) begin
          s2_op   <= OP_NONE;
          s2_addr <= '0;
          s2_mask <= '0;
        end else if (en) begin
          s2_op   <= s1_op;
          s2_addr <= s1_addr;
          s2_mask <= s1_mask;
        end
      end
      assign cm_op   = s2_op;
      assign cm_addr = s2_addr;
      assign cm_mask = s2_mask;
    end else begin : g_late1
      assign cm_op   = s1_op;
      assign cm_addr = s1_addr;
      assign cm_mask = s1_mask;
    end
  endgenerate

endmodule

// File: rtl/lw_mem_array.sv
module lw_mem_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];
      always_ff @(posedge clk) begin
        if (wr_en && wr_mask[g]) begin
          bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end
      end
      assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
    end
  endgenerate

endmodule

// File: rtl/lw_read_stage.sv
module lw_read_stage
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  lw_op_e                  rd_op,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [LANES*LANE_W-1:0] arr_word,
  input  lw_op_e                  cm_op,
  input  logic [ADDR_W-1:0]       cm_addr,
  input  logic [LANES-1:0]        cm_mask,
  input  logic [LANES*LANE_W-1:0] wr_word,
  output logic                    vld,
  output logic [LANES*LANE_W-1:0] word
);

  logic                    hit;
  logic [LANES*LANE_W-1:0] merged;

  assign hit = (cm_op == OP_WR) && (cm_addr == rd_addr);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_fwd
      assign merged[g*LANE_W +: LANE_W] = (hit && cm_mask[g]) ?
                                          wr_word[g*LANE_W +: LANE_W] :
                                          arr_word[g*LANE_W +: LANE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      word <= '0;
    end else if (en) begin
      vld <= (rd_op == OP_RD);
      if (rd_op == OP_RD) word <= merged;
    end
  end

endmodule

// File: rtl/lw_sram_core.sv
module lw_sram_core
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int LANES        = 2,
  parameter int LANE_W       = 9,
  parameter bit PIPELINED    = 1'b1,
  parameter bit LINEAR_BURST = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    we_n,
  input  logic                    load_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dq_in,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int DW = LANES * LANE_W;

  logic              en;
  lw_op_e            nw_op, s1_op, cm_op;
  logic [ADDR_W-1:0] nw_addr, s1_addr, cm_addr;
  logic [LANES-1:0]  nw_mask, cm_mask;
  logic [DW-1:0]     arr_word, rd_word;
  logic              rd_vld;

  assign en = !clk_en_n;

  lw_cmd_decode #(.ADDR_W(ADDR_W), .LANES(LANES), .LINEAR_BURST(LINEAR_BURST)) u_dec (
    .clk(clk), .rst(rst), .en(en),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .we_n(we_n), .load_n(load_n), .lane_wr_n(lane_wr_n), .addr(addr),
    .op(nw_op), .op_addr(nw_addr), .op_mask(nw_mask)
  );

  lw_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .PIPELINED(PIPELINED)) u_pipe (
    .clk(clk), .rst(rst), .en(en),
    .in_op(nw_op), .in_addr(nw_addr), .in_mask(nw_mask),
    .s1_op(s1_op), .s1_addr(s1_addr),
    .cm_op(cm_op), .cm_addr(cm_addr), .cm_mask(cm_mask)
  );

  lw_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk),
    .wr_en(en && (cm_op == OP_WR)),
    .wr_mask(cm_mask), .wr_addr(cm_addr), .wr_data(dq_in),
    .rd_addr(s1_addr), .rd_data(arr_word)
  );

  generate
    if (PIPELINED) begin : g_outreg
      lw_read_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
        .clk(clk), .rst(rst), .en(en),
        .rd_op(s1_op), .rd_addr(s1_addr), .arr_word(arr_word),
        .cm_op(cm_op), .cm_addr(cm_addr), .cm_mask(cm_mask), .wr_word(dq_in),
        .vld(rd_vld), .word(rd_word)
      );
    end else begin : g_flow
      assign rd_vld  = (s1_op == OP_RD);
      assign rd_word = arr_word;
    end
  endgenerate

  assign dq_oe  = rd_vld && !oe_n;
  assign dq_out = dq_oe ? rd_word : '0;

endmodule

// File: rtl/lw_sram_core_chk.sv
module lw_sram_core_chk #(
  parameter bit PIPELINED = 1'b1,
  parameter int DW        = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          clk_en_n,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic          we_n,
  input logic          load_n,
  input logic          oe_n,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe
);

  logic start, sel_all, rd_go, wr_go, ds_go;
  logic rd_q, wr_q, ds_q, rst_q;

  assign start   = !clk_en_n && !load_n;
  assign sel_all = !sel_a_n && sel_b && !sel_c_n;
  assign rd_go   = start && sel_all && we_n;
  assign wr_go   = start && sel_all && !we_n;
  assign ds_go   = start && !sel_all;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      ds_q <= 1'b0;
    end else begin
      rd_q <= rd_go;
      wr_q <= wr_go;
      ds_q <= ds_go;
    end
  end

  always @(posedge clk) begin
    if (rst_q && rst) begin
      assert_reset_quiet_R1: assert (!dq_oe);
    end
  end

  assert_oe_forces_off_R11: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_oe);

  assert_stall_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    (clk_en_n && !oe_n) |=> (oe_n || ($stable(dq_oe) && $stable(dq_out))));

  generate
    if (PIPELINED) begin : g_pipe
      assert_read_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_q && !clk_en_n) |=> (oe_n || dq_oe));
      assert_write_hiz_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_q && !clk_en_n) |=> !dq_oe);
      assert_deselect_hiz_R2: assert property (@(posedge clk) disable iff (rst)
        (ds_q && !clk_en_n) |=> !dq_oe);
    end else begin : g_flow
      assert_read_latency_R3: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> (oe_n || dq_oe));
      assert_write_hiz_R10: assert property (@(posedge clk) disable iff (rst)
        wr_go |=> !dq_oe);
      assert_deselect_hiz_R2: assert property (@(posedge clk) disable iff (rst)
        ds_go |=> !dq_oe);
    end
  endgenerate

endmodule

bind lw_sram_core lw_sram_core_chk #(.PIPELINED(PIPELINED), .DW(LANES*LANE_W)) u_chk (
  .clk(clk), .rst(rst), .clk_en_n(clk_en_n),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
  .we_n(we_n), .load_n(load_n), .oe_n(oe_n),
  .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/lw_sram_core_tb.sv
`timescale 1ns/1ps
module lw_sram_core_tb;

  localparam int AW = 6, LN = 2, LW = 9, DW = LN * LW, DEPTH = 1 << AW;
  localparam int FULL = (1 << LN) - 1;

  logic clk = 1'b0;
  logic rst, clk_en_n, sel_a_n, sel_b, sel_c_n, we_n, load_n, oe_n;
  logic [LN-1:0] lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] q_p, q_f;
  logic          oe_p, oe_f;

  always #2 clk = ~clk;

  lw_sram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .PIPELINED(1'b1), .LINEAR_BURST(1'b1)) u_dut (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .we_n(we_n), .load_n(load_n), .lane_wr_n(lane_wr_n), .addr(addr), .dq_in(dq_in),
    .oe_n(oe_n), .dq_out(q_p), .dq_oe(oe_p));

  lw_sram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .PIPELINED(1'b0), .LINEAR_BURST(1'b0)) u_dut_ft (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .we_n(we_n), .load_n(load_n), .lane_wr_n(lane_wr_n), .addr(addr), .dq_in(dq_in),
    .oe_n(oe_n), .dq_out(q_f), .dq_oe(oe_f));

  // behavioural model, index 0 = pipelined/linear, 1 = flow-through/interleaved
  int  mem [2][DEPTH];
  bit  known [2][DEPTH];
  int  c1op[2], c1ad[2], c2op[2], c2ad[2], c2mk[2], c1mk[2];
  int  bop[2], base[2], stp[2], pd[2];
  bit  pv[2], pk[2];
  int  vectors = 0, fails = 0;
  bit  done = 1'b0;
  string cur_req = "R1";

  function automatic int merge(input int old, input int nd, input int mk);
    int r = old;
    for (int g = 0; g < LN; g++)
      if (mk[g]) r = (r & ~(511 << (9*g))) | (nd & (511 << (9*g)));
    return r;
  endfunction

  task automatic commit(input int m, input int a, input int mk);
    mem[m][a] = merge(mem[m][a], int'(dq_in), mk);
    if (mk == FULL) known[m][a] = 1'b1;
  endtask

  task automatic model_edge();
    for (int m = 0; m < 2; m++) begin
      int op, ad, mk;
      if (rst) begin
        c1op[m] = 0; c2op[m] = 0; bop[m] = 0; base[m] = 0; stp[m] = 0; pv[m] = 1'b0;
        continue;
      end
      if (clk_en_n) continue;
      if (m == 0) begin
        if (c2op[0] == 2) commit(0, c2ad[0], c2mk[0]);
        pv[0] = (c1op[0] == 1);
        if (pv[0]) begin pd[0] = mem[0][c1ad[0]]; pk[0] = known[0][c1ad[0]]; end
        c2op[0] = c1op[0]; c2ad[0] = c1ad[0]; c2mk[0] = c1mk[0];
      end else begin
        if (c1op[1] == 2) commit(1, c1ad[1], c1mk[1]);
      end
      if (!load_n) begin
        op = (!sel_a_n && sel_b && !sel_c_n) ? (we_n ? 1 : 2) : 0;
        ad = int'(addr);
        bop[m] = op; base[m] = ad; stp[m] = 0;
      end else begin
        op = bop[m];
        if (op != 0) stp[m] = (stp[m] + 1) % 4;
        ad = (base[m] & ~3) | ((m == 0) ? ((base[m] + stp[m]) & 3) : ((base[m] ^ stp[m]) & 3));
      end
      mk = (op == 2) ? (~int'(lane_wr_n) & FULL) : 0;
      c1op[m] = op; c1ad[m] = ad; c1mk[m] = mk;
    end
  endtask

  task automatic compare();
    for (int m = 0; m < 2; m++) begin
      bit eo, ek, go;
      int ed;
      logic [DW-1:0] gq;
      if (m == 0) begin eo = pv[0]; ed = pd[0]; ek = pk[0]; end
      else begin eo = (c1op[1] == 1); ed = mem[1][c1ad[1]]; ek = known[1][c1ad[1]]; end
      eo = eo && !oe_n;
      go = (m == 0) ? oe_p : oe_f;
      gq = (m == 0) ? q_p : q_f;
      vectors++;
      if (go !== eo) begin
        fails++;
        $display("FAIL %s mode%0d dq_oe got %b exp %b at %0t", cur_req, m, go, eo, $time);
      end
      if (eo && ek) begin
        vectors++;
        if (gq !== DW'(ed)) begin
          fails++;
          $display("FAIL %s mode%0d dq_out got %h exp %h at %0t", cur_req, m, gq, DW'(ed), $time);
        end
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  // kind: 0 deselect, 1 read, 2 write, 3 continue, 4 stall
  task automatic drv(input int kind, input int a, input int bwn);
    clk_en_n  = (kind == 4);
    load_n    = (kind == 3);
    sel_a_n   = (kind == 0);
    sel_b     = 1'b1;
    sel_c_n   = 1'b0;
    we_n      = (kind != 2);
    lane_wr_n = LN'(bwn);
    addr      = AW'(a);
    dq_in     = DW'($urandom);
    cyc();
  endtask

  task automatic drv_sel(input logic an, input logic b, input logic cn);
    clk_en_n = 1'b0; load_n = 1'b0; we_n = 1'b1;
    sel_a_n = an; sel_b = b; sel_c_n = cn;
    addr = AW'($urandom); dq_in = DW'($urandom);
    cyc();
  endtask

  // R11: output enable acts without a clock edge
  task automatic oe_probe(input int m);
    logic g;
    oe_n = 1'b1; #0.5;
    g = (m == 0) ? oe_p : oe_f;
    vectors++;
    if (g !== 1'b0) begin fails++; $display("FAIL R11 mode%0d dq_oe got %b exp 0", m, g); end
    oe_n = 1'b0; #0.5;
    g = (m == 0) ? oe_p : oe_f;
    vectors++;
    if (g !== 1'b1) begin fails++; $display("FAIL R11 mode%0d dq_oe got %b exp 1", m, g); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired got hang exp completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; clk_en_n = 1'b0; sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
    we_n = 1'b1; load_n = 1'b0; oe_n = 1'b0; lane_wr_n = '1; addr = '0; dq_in = '0;
    for (int m = 0; m < 2; m++) begin pv[m] = 1'b0; c1op[m] = 0; c2op[m] = 0; end
    cur_req = "R1";
    repeat (3) cyc();
    rst = 1'b0;
    cur_req = "R8";                     // continue straight after reset selects nothing
    repeat (3) drv(3, 0, 0);
    drv(0, 0, 0);
    repeat (3) drv(3, 0, 0);

    cur_req = "R4";                     // fill every word with full-lane writes
    for (int a = 0; a < DEPTH; a++) drv(2, a, 0);
    drv(0, 0, 0); drv(0, 0, 0);

    cur_req = "R3";
    for (int a = 0; a < 8; a++) drv(1, a * 7 % DEPTH, 3);
    drv(0, 0, 0); drv(0, 0, 0);

    cur_req = "R6";                     // back-to-back turnaround, forwarding
    drv(2, 9, 0); drv(1, 9, 3); drv(2, 9, 0); drv(1, 9, 3);
    drv(1, 10, 3); drv(2, 10, 0); drv(1, 10, 3); drv(1, 9, 3);
    drv(2, 11, 2); drv(1, 11, 3); drv(0, 0, 0); drv(0, 0, 0);

    cur_req = "R5";
    drv(2, 12, 2); drv(2, 13, 1); drv(0, 0, 0); drv(1, 12, 3); drv(1, 13, 3);
    drv(0, 0, 0); drv(0, 0, 0);

    cur_req = "R12";
    drv(2, 14, 3); drv(2, 14, 3); drv(0, 0, 0); drv(1, 14, 3);
    drv(0, 0, 0); drv(0, 0, 0);

    cur_req = "R7";
    drv(1, 21, 3); repeat (5) drv(3, 0, 3);
    drv(2, 30, 0); repeat (4) drv(3, 0, 0);
    drv(1, 30, 3); repeat (5) drv(3, 0, 3);
    drv(0, 0, 0); drv(0, 0, 0);

    cur_req = "R2";
    drv_sel(1'b1, 1'b1, 1'b0); drv_sel(1'b0, 1'b0, 1'b0); drv_sel(1'b0, 1'b1, 1'b1);
    drv_sel(1'b1, 1'b0, 1'b1); drv_sel(1'b0, 1'b1, 1'b0);
    drv(0, 0, 0); drv(0, 0, 0);

    cur_req = "R9";
    drv(1, 5, 3); drv(4, 6, 3); drv(4, 6, 3); drv(1, 6, 3); drv(4, 7, 0);
    drv(2, 7, 0); drv(4, 7, 0); drv(4, 7, 0); drv(1, 7, 3); drv(4, 0, 3);
    drv(0, 0, 0); drv(0, 0, 0);

    cur_req = "R10";
    drv(1, 3, 3); drv(2, 3, 0); drv(2, 4, 3); drv(1, 4, 3); drv(2, 5, 1);
    drv(0, 0, 0); drv(0, 0, 0);

    cur_req = "R11";
    drv(1, 5, 3); oe_probe(1); drv(0, 0, 0); oe_probe(0);
    drv(0, 0, 0);

    cur_req = "R6";
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom % 8;
      oe_n = (($urandom % 8) == 0);
      if (k == 7) drv_sel(1'($urandom), 1'($urandom), 1'($urandom));
      else drv((k == 0) ? 0 : (k < 3) ? 1 : (k < 5) ? 2 : (k == 5) ? 3 : 4,
               $urandom % 8, $urandom % 4);
    end
    oe_n = 1'b0;
    drv(0, 0, 0); drv(0, 0, 0);
    finish_run();
  end

endmodule